// File: doc/BRIEF.md
# SPI Slave Transmit Shifter with Early-Launch Option

This block is the transmit half of an SPI slave. While the active-low chip select is held low by the external master, it shifts bytes out on MISO, most significant bit first, timed only by the incoming serial clock. The clock polarity (`cpol`) and clock phase (`cpha`) inputs pick one of the four usual SPI timings. A parallel byte port (`tx_data`) supplies the next byte. The block answers each byte it latches with a one-cycle pulse on `tx_taken` in the system clock domain. That pulse is carried across from the serial clock domain by a toggle and a synchroniser.

Setting `hs_en` with `cpha = 0` selects early launch. Each bit after the first then changes on the leading serial clock edge, the same edge on which the master samples the previous bit, rather than on the trailing edge. The data is therefore launched half a serial clock period earlier, which gives a fast master (tens of MHz) more setup margin after the slave's output delay. With `cpha = 1` the early-launch request is ignored.

The shifter is a two-state machine. FRESH is entered asynchronously whenever chip select is high. In FRESH, MISO shows bit 7 of `tx_data` directly. On the first launch edge the machine takes the FRESH→SHIFT transition: it latches `tx_data` and sets the bit index to 1 when `cpha = 0`, or to 0 when `cpha = 1`. In SHIFT, each launch edge advances the index. The SHIFT→SHIFT wrap transition happens when the index reaches 7: it reloads from `tx_data` and returns the index to 0. Raising chip select (SHIFT→FRESH) aborts any partial byte.

Top module: `spi_slave_tx`

## Requirements
- R1: `miso_oe` is 1 exactly while `cs_n` is 0. Bits leave most significant bit first, and consecutive bytes follow without a gap.
- R2: With `cpha = 0` and `hs_en = 0`, MISO presents bit 7 of the first byte as soon as `cs_n` falls. Each later bit appears after a trailing SCLK edge. In the half period after leading edge k the line holds bit number k of the stream (counting from 1); after trailing edge k it holds bit k+1.
- R3: With `cpha = 0` and `hs_en = 1`, MISO changes on the leading edge instead, so the line holds bit k+1 in both half periods of cycle k. Bit 7 of the first byte is still shown from the fall of `cs_n` until leading edge 1.
- R4: With `cpha = 1`, the value of `hs_en` has no effect on MISO timing.
- R5: With `cpha = 1`, the first bit of a transfer is launched on the first leading edge, and each bit k is held through both halves of cycle k.
- R6: The leading edge is the SCLK transition away from the idle level `cpol`. Timing is identical for `cpol = 0` and `cpol = 1` apart from that inversion.
- R7: The next byte is read from `tx_data` at the launch edge that follows the eighth bit of the current byte. With `cpha = 0`, the launch edge after the last bit of a transfer therefore also latches one further byte.
- R8: `tx_taken` is a single `clk` cycle pulse, raised once for each byte latched. A transfer of N bytes gives N pulses with `cpha = 1` and N+1 pulses with `cpha = 0`.
- R9: After `rst_n` is released, `tx_taken` is 0 and, with `cs_n` high, `miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the byte-taken strobe |
| rst_n | input | 1 | Active-low asynchronous reset, system side and toggle flop |
| sclk | input | 1 | Serial clock from the external master |
| cs_n | input | 1 | Active-low chip select |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: first bit ready at select; 1: first bit on first leading edge |
| hs_en | input | 1 | Early-launch request, honoured only when cpha is 0 |
| tx_data | input | DATA_W | Next byte to transmit |
| tx_taken | output | 1 | One-cycle pulse per byte latched |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the MISO pad driver |

## Verification
The in-RTL properties watch the state machine on every launch edge. They check that FRESH always leaves to SHIFT, that the index starts at 0 for `cpha = 1` and wraps to 0 after index 7, that the byte-taken toggle stays still between reloads, and that the system-side strobe never lasts two cycles. The actual half-period placement of each bit can only be shown by the bench scenarios: early against normal launch, the ignored `hs_en` under `cpha = 1`, both clock polarities, and the extra prefetch byte under `cpha = 0`. The bench samples MISO in the middle of every half period and counts strobes per transfer.

// File: rtl/spi_tx_pkg.sv
`timescale 1ns/1ps
package spi_tx_pkg;
    typedef enum logic {
        TX_FRESH = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_e;
endpackage

// File: rtl/spi_tx_clkgen.sv
`timescale 1ns/1ps
// Picks the SCLK edge on which MISO is launched.
module spi_tx_clkgen (
    input  logic sclk,
    input  logic cpol,
    input  logic cpha,
    input  logic hs_en,
    output logic launch_clk
);
    logic lead_clk;     // rising edge = leading SCLK edge
    logic early_eff;    // early launch honoured only for cpha = 0

    assign lead_clk   = sclk ^ cpol;
    assign early_eff  = hs_en & ~cpha;
    assign launch_clk = (cpha | early_eff) ? lead_clk : ~lead_clk;
endmodule

// File: rtl/spi_tx_shifter.sv
`timescale 1ns/1ps
module spi_tx_shifter
    import spi_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              launch_clk,
    input  logic              cs_n,
    input  logic              rst_n,
    input  logic              cpha,
    input  logic [DATA_W-1:0] tx_data,
    output logic              miso,
    output logic              take_tgl
);
    localparam int              IDX_W    = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [DATA_W-1:0] cur_q, cur_d;
    logic              load;

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cur_d   = cur_q;
        load    = 1'b0;
        unique case (state_q)
            TX_FRESH: begin
                load    = 1'b1;
                cur_d   = tx_data;
                idx_d   = cpha ? '0 : IDX_W'(1);
                state_d = TX_SHIFT;
            end
            TX_SHIFT: begin
                if (idx_q == LAST_IDX) begin
                    load  = 1'b1;
                    cur_d = tx_data;
                    idx_d = '0;
                end else begin
                    idx_d = idx_q + IDX_W'(1);
                end
            end
            default: state_d = TX_FRESH;
        endcase
    end

    // state register: chip select high forces FRESH
    always_ff @(posedge launch_clk or posedge cs_n) begin
        if (cs_n) begin
            state_q <= TX_FRESH;
            idx_q   <= '0;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cur_q   <= cur_d;
        end
    end

    // byte-taken toggle, survives chip select
    always_ff @(posedge launch_clk or negedge rst_n) begin
        if (!rst_n) begin
            take_tgl <= 1'b0;
        end else if (load && !cs_n) begin
            take_tgl <= ~take_tgl;
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            TX_FRESH: miso = tx_data[DATA_W-1];
            TX_SHIFT: miso = cur_q[LAST_IDX - idx_q];
            default:  miso = 1'b0;
        endcase
    end

    // R2 / R3: the first launch edge always moves the machine to SHIFT
    p_fresh_exit_r2: assert property (@(posedge launch_clk) disable iff (cs_n)
        (state_q == TX_FRESH) |=> (state_q == TX_SHIFT));

    // R5: cpha = 1 starts the index at the MSB on the first leading edge
    p_cpha1_start_r5: assert property (@(posedge launch_clk) disable iff (cs_n)
        (state_q == TX_FRESH && cpha) |=> (idx_q == '0));

    // R7: after the last bit the index wraps to a new byte
    p_wrap_r7: assert property (@(posedge launch_clk) disable iff (cs_n)
        (state_q == TX_SHIFT && idx_q == LAST_IDX) |=> (idx_q == '0));

    // R8: no byte-taken event in the middle of a byte
    p_hold_take_r8: assert property (@(posedge launch_clk) disable iff (cs_n || !rst_n)
        (state_q == TX_SHIFT && idx_q != LAST_IDX) |=> $stable(take_tgl));
endmodule

// File: rtl/spi_tx_sync.sv
`timescale 1ns/1ps
// Carries the byte-taken toggle into the system clock domain.
module spi_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse_out
);
    logic [STAGES-1:0] sync_q;
    logic              seen_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= tgl_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q    <= 1'b0;
            pulse_out <= 1'b0;
        end else begin
            seen_q    <= sync_q[STAGES-1];
            pulse_out <= sync_q[STAGES-1] ^ seen_q;
        end
    end

    // R8: the strobe is a single-cycle pulse
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |=> !pulse_out);
endmodule

// File: rtl/spi_slave_tx.sv
`timescale 1ns/1ps
module spi_slave_tx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              hs_en,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_taken,
    output logic              miso,
    output logic              miso_oe
);
    logic launch_clk;
    logic take_tgl;

    spi_tx_clkgen u_clkgen (
        .sclk       (sclk),
        .cpol       (cpol),
        .cpha       (cpha),
        .hs_en      (hs_en),
        .launch_clk (launch_clk)
    );

    spi_tx_shifter #(.DATA_W(DATA_W)) u_shifter (
        .launch_clk (launch_clk),
        .cs_n       (cs_n),
        .rst_n      (rst_n),
        .cpha       (cpha),
        .tx_data    (tx_data),
        .miso       (miso),
        .take_tgl   (take_tgl)
    );

    spi_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgl_in    (take_tgl),
        .pulse_out (tx_taken)
    );

    assign miso_oe = ~cs_n;
endmodule

// File: tb/sim_spi_slave_tx.sv
`timescale 1ns/1ps
module sim_spi_slave_tx;
    localparam real HALF = 40.0;   // SCLK half period, ns

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       hs_en = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_taken, miso, miso_oe;

    int n_run = 0;
    int n_fail = 0;
    int take_cnt = 0;

    logic [7:0] tx_q[$];
    logic       exp_bit[$];
    string      exp_tag[$];
    event       chk_ev;

    always #4 clk = ~clk;

    spi_slave_tx u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .cpol(cpol),
        .cpha(cpha), .hs_en(hs_en), .tx_data(tx_data), .tx_taken(tx_taken),
        .miso(miso), .miso_oe(miso_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(chk_ev);
            while (exp_bit.size() > 0) begin
                logic  e;
                string t;
                e = exp_bit.pop_front();
                t = exp_tag.pop_front();
                check(miso === e && miso_oe === 1'b1, t, int'(miso), int'(e));
            end
        end
    end

    // byte feeder, counts strobes (R8)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && tx_taken) begin
                take_cnt++;
                if (tx_q.size() > 0) void'(tx_q.pop_front());
                tx_data = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
            end
        end
    end

    task automatic expect_bit(input logic b, input string tag);
        exp_bit.push_back(b);
        exp_tag.push_back(tag);
        ->chk_ev;
    endtask

    // one transfer as master; mode tag names the requirement under test
    task automatic xfer(input logic p, input logic ph, input logic hs,
                        input int nbytes, input string tag);
        logic s[$];
        int   nb;
        nb = 8 * nbytes;
        tx_q.delete();
        for (int i = 0; i <= nbytes; i++) tx_q.push_back(8'($urandom));
        foreach (tx_q[i]) for (int b = 7; b >= 0; b--) s.push_back(tx_q[i][b]);
        tx_data = tx_q[0];
        cpol = p; cpha = ph; hs_en = hs; sclk = p;
        take_cnt = 0;
        #(HALF);
        cs_n = 1'b0;
        #(HALF / 2);
        if (!ph) expect_bit(s[0], {tag, " pre-edge MSB"});
        #(HALF / 2);
        for (int k = 1; k <= nb; k++) begin
            sclk = ~p;                       // leading edge
            #(HALF / 2);
            if (!ph && hs) expect_bit(s[k],   {tag, " lead half"});
            else           expect_bit(s[k-1], {tag, " lead half"});
            #(HALF / 2);
            sclk = p;                        // trailing edge
            #(HALF / 2);
            if (!ph)       expect_bit(s[k],   {tag, " trail half"});
            else           expect_bit(s[k-1], {tag, " trail half"});
            #(HALF / 2);
        end
        cs_n = 1'b1;
        #(HALF);
        check(miso_oe === 1'b0, {tag, " R1 oe off after select"}, int'(miso_oe), 0);
        #(HALF * 2);
        check(take_cnt == (ph ? nbytes : nbytes + 1), {tag, " R7 R8 strobe count"},
              take_cnt, ph ? nbytes : nbytes + 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_taken === 1'b0, "R9 reset strobe", int'(tx_taken), 0);
        check(miso_oe === 1'b0, "R9 R1 reset oe", int'(miso_oe), 0);

        xfer(1'b0, 1'b0, 1'b0, 2, "R2 normal cpol0");
        xfer(1'b0, 1'b0, 1'b1, 2, "R3 early cpol0");
        xfer(1'b0, 1'b1, 1'b0, 2, "R5 cpha1 cpol0");
        xfer(1'b1, 1'b1, 1'b1, 2, "R4 cpha1 hs ignored cpol1");
        xfer(1'b1, 1'b0, 1'b1, 3, "R6 early cpol1");
        xfer(1'b1, 1'b0, 1'b0, 1, "R6 normal cpol1");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule